// File: doc/BRIEF.md
# Interrupt Thread-Context Ring Matcher

This block decides, for each of several hardware thread contexts evaluated side by side, whether an incoming interrupt notification targets that thread and at which privilege ring it should be presented. A notification carries a format bit, a target block id, a 24-bit virtual-processor index, an ignore flag and a logical-server number. Each thread supplies its processor id, a valid bit for its physical ring, and three context words (hypervisor pool, OS, user). Each word holds its own valid bit and a compare field.

For format 0, the rings are searched in a fixed priority order: physical, then pool, then OS. The physical ring's compare value is not stored. It is formed from the local block id and the thread id taken from the processor id. For format 1, the user-level event notification, the user ring is reported only when both the OS ring and the user ring agree. Format 0 with the ignore flag set (group / logical-server delivery) is not supported and always yields no match. The result is registered: a request strobe produces a one-cycle `out_valid` pulse carrying one match flag and one ring code per thread.

Top module: `thread_ring_matcher`

## Requirements
- R1: After synchronous reset, `out_valid`, every `out_match` bit and every `out_ring` code are 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `req_valid` high, whether or not anything matched. It is 0 otherwise.
- R3: The target compare value is `{req_blk, req_idx}` (4 + 24 = 28 bits). With `req_format`=0 and `req_ignore`=1, every thread reports no match.
- R4: Physical ring (code 3): `phys_valid[t]` is set and the target equals `{local_blk, idx}`. Here idx is 24 bits, with bit 7 = 1, bits 6:0 = `proc_id[t][6:0]`, and all other bits 0. Bit 7 of `proc_id` plays no part. This ring has the highest priority for format 0.
- R5: Pool ring (code 2): `pool_word[t]` bit 28 is set and bits 27:0 equal the target. It is chosen only when the physical ring does not match.
- R6: OS ring (code 1): `os_word[t]` bit 28 is set and bits 27:0 equal the target. It is chosen for format 0 only when neither the physical nor the pool ring matches.
- R7: With `req_format`=1, a thread matches with ring code 0 (user) only when four conditions all hold: the OS valid bit is set, the OS field equals the target, `user_word[t]` bit 8 is set, and `user_word[t]` bits 7:0 equal `req_server`. `req_ignore` has no effect in this format.
- R8: A thread that meets no condition reports `out_match`=0 with ring code 0.
- R9: Each thread is evaluated independently, from its own slice of the per-thread inputs. Slices are packed with thread 0 in the lowest bits.
- R10: Between requests, `out_match` and `out_ring` hold their last values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Notification strobe |
| req_format | input | 1 | 0 = thread notification, 1 = user-level event |
| req_blk | input | BLK_W | Target block id |
| req_idx | input | IDX_W | Target virtual-processor index |
| req_ignore | input | 1 | Low-bits-ignored delivery request |
| req_server | input | SRV_W | Requested logical-server number |
| local_blk | input | BLK_W | Block id of this controller |
| proc_id | input | NUM_THREADS*PID_W | Processor id per thread |
| phys_valid | input | NUM_THREADS | Physical ring valid per thread |
| pool_word | input | NUM_THREADS*(BLK_W+IDX_W+1) | Pool ring {valid, compare field} per thread |
| os_word | input | NUM_THREADS*(BLK_W+IDX_W+1) | OS ring {valid, compare field} per thread |
| user_word | input | NUM_THREADS*(SRV_W+1) | User ring {valid, server} per thread |
| out_valid | output | 1 | Result strobe |
| out_match | output | NUM_THREADS | Match flag per thread |
| out_ring | output | NUM_THREADS*2 | Ring code per thread (3 phys, 2 pool, 1 OS, 0 user) |

## Verification
The embedded assertions cover the timing and the invariants on every cycle. These are: the result strobe follows each request by one cycle; results hold while idle; a format-0 ignore request clears every match; a format-1 request yields only user codes; and a thread without a match has ring code 0. The ring priority, the physical compare value built from the processor id, and the four-way condition for the user ring can only be shown by the bench. It sweeps every combination of valid bits, field agreement, format and ignore flag on two threads, and adds a case where the block ids differ.

// File: rtl/ringmatch_pkg.sv
package ringmatch_pkg;
  localparam logic [1:0] RING_USER = 2'd0;
  localparam logic [1:0] RING_OS   = 2'd1;
  localparam logic [1:0] RING_POOL = 2'd2;
  localparam logic [1:0] RING_PHYS = 2'd3;
endpackage

// File: rtl/rm_phys_cam.sv
module rm_phys_cam #(
  parameter int BLK_W = 4,
  parameter int IDX_W = 24,
  parameter int TID_W = 7,
  parameter int PID_W = 8
) (
  input  logic [BLK_W-1:0]       local_blk,
  input  logic [PID_W-1:0]       pid,
  output logic [BLK_W+IDX_W-1:0] cam
);
  logic [IDX_W-1:0] idx;

  // Marker bit at position TID_W, thread id bits below it, zeros above.
  always_comb begin
    idx            = '0;
    idx[TID_W]     = 1'b1;
    idx[TID_W-1:0] = pid[TID_W-1:0];
    cam            = {local_blk, idx};
  end

  initial begin
    assert (TID_W < IDX_W && TID_W <= PID_W)
      else $error("rm_phys_cam: thread id width does not fit");
  end
endmodule

// File: rtl/rm_thread_sel.sv
module rm_thread_sel
  import ringmatch_pkg::*;
#(
  parameter int CAM_W = 28,
  parameter int SRV_W = 8
) (
  input  logic             fmt,
  input  logic             ignore,
  input  logic [CAM_W-1:0] target,
  input  logic [SRV_W-1:0] server,
  input  logic             phys_v,
  input  logic [CAM_W-1:0] phys_cam,
  input  logic [CAM_W:0]   pool_w,
  input  logic [CAM_W:0]   os_w,
  input  logic [SRV_W:0]   user_w,
  output logic             hit,
  output logic [1:0]       ring
);
  logic phys_hit, pool_hit, os_hit, user_hit;

  always_comb begin
    phys_hit = phys_v && (phys_cam == target);
    pool_hit = pool_w[CAM_W] && (pool_w[CAM_W-1:0] == target);
    os_hit   = os_w[CAM_W] && (os_w[CAM_W-1:0] == target);
    user_hit = os_hit && user_w[SRV_W] && (user_w[SRV_W-1:0] == server);
  end

  always_comb begin
    hit  = 1'b0;
    ring = RING_USER;
    if (fmt) begin
      if (user_hit) begin
        hit  = 1'b1;
        ring = RING_USER;
      end
    end else if (!ignore) begin
      if (phys_hit) begin
        hit  = 1'b1;
        ring = RING_PHYS;
      end else if (pool_hit) begin
        hit  = 1'b1;
        ring = RING_POOL;
      end else if (os_hit) begin
        hit  = 1'b1;
        ring = RING_OS;
      end
    end
  end
endmodule

// File: rtl/thread_ring_matcher.sv
module thread_ring_matcher
  import ringmatch_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int BLK_W       = 4,
  parameter int IDX_W       = 24,
  parameter int TID_W       = 7,
  parameter int PID_W       = 8,
  parameter int SRV_W       = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  input  logic                                   req_format,
  input  logic [BLK_W-1:0]                       req_blk,
  input  logic [IDX_W-1:0]                       req_idx,
  input  logic                                   req_ignore,
  input  logic [SRV_W-1:0]                       req_server,
  input  logic [BLK_W-1:0]                       local_blk,
  input  logic [NUM_THREADS*PID_W-1:0]           proc_id,
  input  logic [NUM_THREADS-1:0]                 phys_valid,
  input  logic [NUM_THREADS*(BLK_W+IDX_W+1)-1:0] pool_word,
  input  logic [NUM_THREADS*(BLK_W+IDX_W+1)-1:0] os_word,
  input  logic [NUM_THREADS*(SRV_W+1)-1:0]       user_word,
  output logic                                   out_valid,
  output logic [NUM_THREADS-1:0]                 out_match,
  output logic [NUM_THREADS*2-1:0]               out_ring
);
  localparam int CAM_W = BLK_W + IDX_W;
  localparam int CTX_W = CAM_W + 1;
  localparam int USR_W = SRV_W + 1;

  logic [CAM_W-1:0]       target;
  logic [NUM_THREADS-1:0] hit_c;
  logic [NUM_THREADS*2-1:0] ring_c;

  assign target = {req_blk, req_idx};

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [CAM_W-1:0] pcam;

    rm_phys_cam #(.BLK_W(BLK_W), .IDX_W(IDX_W), .TID_W(TID_W), .PID_W(PID_W)) u_pcam (
      .local_blk (local_blk),
      .pid       (proc_id[t*PID_W +: PID_W]),
      .cam       (pcam)
    );

    rm_thread_sel #(.CAM_W(CAM_W), .SRV_W(SRV_W)) u_sel (
      .fmt      (req_format),
      .ignore   (req_ignore),
      .target   (target),
      .server   (req_server),
      .phys_v   (phys_valid[t]),
      .phys_cam (pcam),
      .pool_w   (pool_word[t*CTX_W +: CTX_W]),
      .os_w     (os_word[t*CTX_W +: CTX_W]),
      .user_w   (user_word[t*USR_W +: USR_W]),
      .hit      (hit_c[t]),
      .ring     (ring_c[t*2 +: 2])
    );

    // R8
    no_match_ring_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !out_match[t] |-> out_ring[t*2 +: 2] == RING_USER);

    // R7
    user_fmt_ring_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_format) |=> out_ring[t*2 +: 2] == RING_USER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_match <= '0;
      out_ring  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_match <= hit_c;
        out_ring  <= ring_c;
      end
    end
  end

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  // R2
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  // R3
  ignore_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_format && req_ignore) |=> out_match == '0);

  // R10
  hold_results_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(out_match) && $stable(out_ring)));
endmodule

// File: tb/tb_thread_ring_matcher.sv
module tb_thread_ring_matcher;
  localparam int NT = 2, BW = 4, IW = 24, PW = 8, SW = 8;
  localparam int CW = BW + IW;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_format = 0, req_ignore = 0;
  logic [BW-1:0] req_blk = '0, local_blk = '0;
  logic [IW-1:0] req_idx = '0;
  logic [SW-1:0] req_server = '0;
  logic [NT*PW-1:0] proc_id = '0;
  logic [NT-1:0] phys_valid = '0;
  logic [NT*(CW+1)-1:0] pool_word = '0, os_word = '0;
  logic [NT*(SW+1)-1:0] user_word = '0;
  logic out_valid;
  logic [NT-1:0] out_match;
  logic [NT*2-1:0] out_ring;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  thread_ring_matcher #(.NUM_THREADS(NT), .BLK_W(BW), .IDX_W(IW), .TID_W(7),
                        .PID_W(PW), .SRV_W(SW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // pattern bits: 0 phys_v,1 phys_eq,2 pool_v,3 pool_eq,4 os_v,5 os_eq,6 user_v,7 srv_eq
  function automatic logic [2:0] expect_of(input logic [7:0] p, input logic fmt, input logic ign);
    if (fmt) return (p[4] && p[5] && p[6] && p[7]) ? 3'b100 : 3'b000;
    if (ign) return 3'b000;
    if (p[0] && p[1]) return 3'b111;
    if (p[2] && p[3]) return 3'b110;
    if (p[4] && p[5]) return 3'b101;
    return 3'b000;
  endfunction

  task automatic setup_thread(input int t, input logic [7:0] p, input int c,
                              input logic [CW-1:0] tgt, input logic [6:0] tid);
    proc_id[t*PW +: PW]        = p[1] ? {c[1], tid} : {c[1], tid ^ 7'h40};
    phys_valid[t]              = p[0];
    pool_word[t*(CW+1) +: CW+1] = {p[2], p[3] ? tgt : tgt ^ (28'h1 << (c % 28))};
    os_word[t*(CW+1) +: CW+1]   = {p[4], p[5] ? tgt : tgt ^ (28'h1 << ((c + 5) % 28))};
    user_word[t*(SW+1) +: SW+1] = {p[6], p[7] ? req_server : req_server ^ 8'h80};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_match", out_match, 0);
    chk("R1 out_ring", out_ring, 0);
    rst = 0;
    @(negedge clk);
    chk("R2 idle strobe", out_valid, 0);

    // Sweep: R3 R4 R5 R6 R7 R8 R9
    for (int c = 0; c < 1024; c++) begin
      logic [6:0] tid;
      logic [CW-1:0] tgt;
      logic [7:0] p0, p1;
      tid = c[6:0];
      req_blk = c[3:0];
      local_blk = c[3:0];
      req_idx = 24'h80 | IW'(tid);
      tgt = {req_blk, req_idx};
      req_server = c[7:0] ^ 8'h3C;
      req_format = c[9];
      req_ignore = c[8];
      p0 = c[7:0];
      p1 = c[7:0] ^ 8'h5A;
      setup_thread(0, p0, c, tgt, tid);
      setup_thread(1, p1, c, tgt, tid);
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      begin
        logic [2:0] e0, e1;
        e0 = expect_of(p0, c[9], c[8]);
        e1 = expect_of(p1, c[9], c[8]);
        chk("R2 strobe after request", out_valid, 1);
        chk("R4/R5/R6/R7/R3 thread0 match", out_match[0], e0[2]);
        chk("R4/R5/R6/R7/R8 thread0 ring", out_ring[1:0], e0[1:0]);
        chk("R9 thread1 match", out_match[1], e1[2]);
        chk("R9 thread1 ring", out_ring[3:2], e1[1:0]);
      end
    end

    // R10: outputs hold while inputs move with no request
    begin
      logic [NT-1:0] m;
      logic [NT*2-1:0] r;
      @(negedge clk);
      chk("R2 no strobe without request", out_valid, 0);
      m = out_match; r = out_ring;
      phys_valid = '1; pool_word = '1; os_word = '1; user_word = '1;
      req_format = ~req_format; req_ignore = 0;
      repeat (4) @(negedge clk);
      chk("R10 match held", out_match, m);
      chk("R10 ring held", out_ring, r);
    end

    // R4: block id mismatch defeats physical match even with right thread id
    req_format = 0; req_ignore = 0;
    req_blk = 4'h6; local_blk = 4'h7; req_idx = 24'h80 | 24'h15;
    proc_id = {8'h15, 8'h95};
    phys_valid = '1; pool_word = '0; os_word = '0; user_word = '0;
    req_valid = 1; @(negedge clk); req_valid = 0;
    chk("R4 block mismatch no match", out_match, 0);
    local_blk = 4'h6;
    req_valid = 1; @(negedge clk); req_valid = 0;
    chk("R4 block equal both threads phys", out_match, 2'b11);
    chk("R4 ring phys code 3", out_ring, 4'hF);

    // R2: back-to-back requests give back-to-back strobes
    req_valid = 1; @(negedge clk);
    chk("R2 first of pair", out_valid, 1);
    @(negedge clk); req_valid = 0;
    chk("R2 second of pair", out_valid, 1);
    @(negedge clk);
    chk("R2 strobe ends", out_valid, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule